// File: doc/BRIEF.md
# VLAN Tag Hash Filter

This block decides whether a received VLAN-tagged frame is accepted by group filtering. Software loads a 16-bit hash table through a simple register write port that has per-byte enables and a selectable byte ordering. The receive path presents a 16-bit tag with a strobe. The block hashes either the whole tag or only its 12-bit identifier with the Ethernet CRC-32, turns part of the result into a 4-bit index, and reports whether the selected table bit is set.

The table lives in the register clock domain and is carried to the receive clock domain as one 16-bit word. A toggle handshake through two-flop synchronizers does the transfer. A transfer starts only when software writes one particular byte lane, and that lane depends on the byte-ordering setting. Software can therefore change the table one byte at a time without the filter ever using a half-written table. When filtering is disabled, every tag is accepted.

Top module: `vlan_hash_filter`

## Requirements
- R1: After reset the table is all zeros in both clock domains, so with filtering enabled every tag is rejected until a copy is triggered.
- R2: A write with `cfg_wr_be[0]` set loads table bits 7:0 from `cfg_wr_data[7:0]`. A write with `cfg_wr_be[1]` set loads bits 15:8 from `cfg_wr_data[15:8]`.
- R3: A copy to the receive domain starts only on a write whose enables include the trigger lane. With `cfg_big_endian`=0 the trigger lane is bits 15:8 (`cfg_wr_be[1]`). With `cfg_big_endian`=1 it is bits 7:0 (`cfg_wr_be[0]`). A write to the other lane alone leaves the filter's table unchanged until a later trigger write.
- R4: The hash is CRC-32 with polynomial 0x04C11DB7, the register preset to all ones and the result inverted. Tag bits are fed least significant first. All 16 tag bits are used when `rx_id_only`=0, and only bits 11:0 when `rx_id_only`=1.
- R5: The index is the upper four bits of the bit-reversed CRC result, read as an unsigned number. Index n selects table bit n, so 4'b1000 selects bit 8.
- R6: With `rx_hash_en`=1 a tag passes (`rx_res_pass`=1) when the selected table bit is 1 and is rejected when it is 0.
- R7: With `rx_hash_en`=0 the table is ignored and every tag passes.
- R8: `rx_res_vld` is a one-cycle pulse in the second `rx_clk` cycle after the edge that samples `rx_tag_vld`. It is low at all other times, and `rx_res_pass` is 0 whenever `rx_res_vld` is 0.
- R9: The receive-side table changes only as a whole 16-bit word. When trigger writes come faster than the handshake completes, the value left by the last trigger write is the one finally delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register-side clock |
| cfg_rst_n | input | 1 | Register-side asynchronous active-low reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_be | input | 2 | Byte enables, bit 0 for bits 7:0, bit 1 for bits 15:8 |
| cfg_wr_data | input | 16 | Table write data |
| cfg_big_endian | input | 1 | Byte-ordering setting that selects the trigger lane |
| rx_clk | input | 1 | Receive-side clock |
| rx_rst_n | input | 1 | Receive-side asynchronous active-low reset |
| rx_hash_en | input | 1 | Enables hash filtering on the tag |
| rx_id_only | input | 1 | 1 hashes the 12-bit identifier, 0 hashes the full tag |
| rx_tag_vld | input | 1 | Tag strobe |
| rx_tag | input | 16 | Received VLAN tag |
| rx_res_vld | output | 1 | Result strobe |
| rx_res_pass | output | 1 | 1 when the frame passes |

## Verification
The hardest situation to reach from the ports is a table write that lands while an earlier copy is still crossing the clock boundary. The sender must hold its outgoing word steady, and it must still deliver the last value written. The bench reaches this with trigger writes on consecutive register clocks, using clocks of unrelated periods. It also writes the non-trigger lane alone in both byte orderings and then runs tags through the filter. This shows the old table still in force until the trigger lane is written.

// File: rtl/vhf_pkg.sv
`timescale 1ns/1ps
package vhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    LANES_LITTLE = 1'b0,
    LANES_BIG    = 1'b1
  } lane_order_e;
endpackage

// File: rtl/vhf_sync.sv
`timescale 1ns/1ps
module vhf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/vhf_cfg_side.sv
`timescale 1ns/1ps
module vhf_cfg_side
  import vhf_pkg::*;
#(
  parameter int unsigned TBL_W = 16,
  localparam int unsigned LANES = TBL_W / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [TBL_W-1:0] wr_data,
  input  logic             big_endian,
  input  logic             ack_sync,
  output logic [TBL_W-1:0] hold_q,
  output logic             req_q
);
  logic [TBL_W-1:0] tbl_q, tbl_d;
  logic [LANES-1:0] lane_wr;
  logic             pend_q, pend_d;
  logic             req_d;
  logic [TBL_W-1:0] hold_d;
  logic             trig, busy, launch;
  lane_order_e      order;

  assign order = lane_order_e'(big_endian);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wr[l] = wr_en & wr_be[l];
    assign tbl_d[l*LANE_W +: LANE_W] = lane_wr[l] ? wr_data[l*LANE_W +: LANE_W]
                                                  : tbl_q[l*LANE_W +: LANE_W];
  end

  always_comb begin
    trig   = (order == LANES_BIG) ? lane_wr[0] : lane_wr[LANES-1];
    busy   = req_q ^ ack_sync;
    launch = pend_q & ~busy;
    pend_d = trig | (pend_q & ~launch);
    req_d  = req_q ^ launch;
    hold_d = launch ? tbl_q : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (|lane_wr) tbl_q <= tbl_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      if (launch) hold_q <= hold_d;
    end
  end

  // R3
  nontrig_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig && !pend_q) |=> !pend_q);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(hold_q));
  // R9
  trig_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend_q);
endmodule

// File: rtl/vhf_tbl_rx.sv
`timescale 1ns/1ps
module vhf_tbl_rx #(
  parameter int unsigned TBL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic [TBL_W-1:0] hold,
  output logic [TBL_W-1:0] tbl_q,
  output logic             ack_q
);
  logic seen_q;
  logic take;

  always_comb take = req_sync ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      tbl_q  <= '0;
    end else begin
      seen_q <= req_sync;
      if (take) tbl_q <= hold;
    end
  end

  assign ack_q = seen_q;

  // R9
  tbl_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(tbl_q));
  // R9
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
endmodule

// File: rtl/vhf_hash_pipe.sv
`timescale 1ns/1ps
module vhf_hash_pipe
  import vhf_pkg::*;
#(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned ID_W  = 12,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned TBL_W = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_vld,
  input  logic [TAG_W-1:0] tag,
  input  logic             hash_en,
  input  logic             id_only,
  input  logic [TBL_W-1:0] tbl,
  output logic             res_vld,
  output logic             res_pass
);
  function automatic logic [CRC_W-1:0] tag_crc(input logic [TAG_W-1:0] d,
                                               input logic only_id);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '1;
    for (int i = 0; i < TAG_W; i++) begin
      if (!only_id || (i < ID_W)) begin
        fb = c[CRC_W-1] ^ d[i];
        c  = {c[CRC_W-2:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return ~c;
  endfunction

  logic [CRC_W-1:0] crc;
  logic [IDX_W-1:0] idx_d, s1_idx;
  logic             s1_vld, s1_en;
  logic             pass_d;

  always_comb begin
    crc = tag_crc(tag, id_only);
    for (int k = 0; k < IDX_W; k++) idx_d[IDX_W-1-k] = crc[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_en  <= 1'b0;
      s1_idx <= '0;
    end else begin
      s1_vld <= tag_vld;
      if (tag_vld) begin
        s1_en  <= hash_en;
        s1_idx <= idx_d;
      end
    end
  end

  always_comb pass_d = s1_vld & (~s1_en | tbl[s1_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_pass <= 1'b0;
    end else begin
      res_vld  <= s1_vld;
      res_pass <= pass_d;
    end
  end

  // R8
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_vld |=> s1_vld);
  // R8
  result_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> res_vld);
  // R8
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !res_vld);
  // R8
  pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !res_pass);
  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_en) |=> res_pass);
endmodule

// File: rtl/vlan_hash_filter.sv
`timescale 1ns/1ps
module vlan_hash_filter
  import vhf_pkg::*;
#(
  parameter int unsigned TAG_W       = 16,
  parameter int unsigned ID_W        = 12,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TBL_W = 1 << IDX_W,
  localparam int unsigned LANES = TBL_W / LANE_W
) (
  input  logic             cfg_clk,
  input  logic             cfg_rst_n,
  input  logic             cfg_wr_en,
  input  logic [LANES-1:0] cfg_wr_be,
  input  logic [TBL_W-1:0] cfg_wr_data,
  input  logic             cfg_big_endian,
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             rx_hash_en,
  input  logic             rx_id_only,
  input  logic             rx_tag_vld,
  input  logic [TAG_W-1:0] rx_tag,
  output logic             rx_res_vld,
  output logic             rx_res_pass
);
  logic [TBL_W-1:0] hold;
  logic             req, req_rx, ack, ack_cfg;
  logic [TBL_W-1:0] tbl_rx;

  vhf_cfg_side #(.TBL_W(TBL_W)) u_cfg (
    .clk        (cfg_clk),
    .rst_n      (cfg_rst_n),
    .wr_en      (cfg_wr_en),
    .wr_be      (cfg_wr_be),
    .wr_data    (cfg_wr_data),
    .big_endian (cfg_big_endian),
    .ack_sync   (ack_cfg),
    .hold_q     (hold),
    .req_q      (req)
  );

  vhf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk (rx_clk), .rst_n (rx_rst_n), .d (req), .q (req_rx)
  );

  vhf_tbl_rx #(.TBL_W(TBL_W)) u_rx_tbl (
    .clk      (rx_clk),
    .rst_n    (rx_rst_n),
    .req_sync (req_rx),
    .hold     (hold),
    .tbl_q    (tbl_rx),
    .ack_q    (ack)
  );

  vhf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (cfg_clk), .rst_n (cfg_rst_n), .d (ack), .q (ack_cfg)
  );

  vhf_hash_pipe #(.TAG_W(TAG_W), .ID_W(ID_W), .IDX_W(IDX_W)) u_pipe (
    .clk      (rx_clk),
    .rst_n    (rx_rst_n),
    .tag_vld  (rx_tag_vld),
    .tag      (rx_tag),
    .hash_en  (rx_hash_en),
    .id_only  (rx_id_only),
    .tbl      (tbl_rx),
    .res_vld  (rx_res_vld),
    .res_pass (rx_res_pass)
  );
endmodule

// File: tb/tb_vlan_hash_filter.sv
`timescale 1ns/1ps
module tb_vlan_hash_filter;
  logic        cfg_clk = 1'b0, rx_clk = 1'b0;
  logic        cfg_rst_n = 1'b0, rx_rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_big_endian = 1'b0;
  logic [1:0]  cfg_wr_be = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        rx_hash_en = 1'b0, rx_id_only = 1'b0, rx_tag_vld = 1'b0;
  logic [15:0] rx_tag = '0;
  logic        rx_res_vld, rx_res_pass;

  always #7 cfg_clk = ~cfg_clk;
  always #5 rx_clk  = ~rx_clk;

  vlan_hash_filter dut (.*);

  int    n_tests = 0, n_fail = 0, cyc = 0;
  bit    finished = 0;
  string cur_req = "R8";
  logic [15:0] m_cfg_tbl = '0, m_rx_tbl = '0;
  logic  m0_vld = 0, m0_pass = 0, m1_vld = 0, m1_pass = 0;

  // reflected-form CRC; the result is already bit-reversed
  function automatic logic [3:0] ref_idx(logic [15:0] t, logic idonly);
    logic [31:0] c = 32'hFFFF_FFFF;
    int n = idonly ? 12 : 16;
    for (int i = 0; i < n; i++) begin
      if (c[0] ^ t[i]) c = (c >> 1) ^ 32'hEDB8_8320;
      else             c = c >> 1;
    end
    c = ~c;
    return c[31:28];
  endfunction

  always @(posedge rx_clk) begin
    m1_vld  <= m0_vld;
    m1_pass <= m0_pass;
    m0_vld  <= rx_tag_vld;
    m0_pass <= rx_tag_vld && (!rx_hash_en || m_rx_tbl[ref_idx(rx_tag, rx_id_only)]);
  end

  always @(negedge rx_clk) begin
    if (rx_rst_n && (m1_vld || rx_res_vld)) begin
      n_tests++;
      if (rx_res_vld !== m1_vld || rx_res_pass !== m1_pass) begin
        n_fail++;
        $display("FAIL %s: vld/pass=%0b/%0b expected %0b/%0b", cur_req,
                 rx_res_vld, rx_res_pass, m1_vld, m1_pass);
      end
    end
  end

  always @(posedge rx_clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(logic [15:0] d, logic [1:0] be, logic big);
    @(negedge cfg_clk);
    cfg_wr_en = 1; cfg_wr_data = d; cfg_wr_be = be; cfg_big_endian = big;
    if (be[0]) m_cfg_tbl[7:0]  = d[7:0];
    if (be[1]) m_cfg_tbl[15:8] = d[15:8];
    if (big ? be[0] : be[1]) m_rx_tbl = m_cfg_tbl;
    @(negedge cfg_clk);
    cfg_wr_en = 0; cfg_wr_be = '0;
  endtask

  task automatic settle();
    repeat (40) @(negedge rx_clk);
  endtask

  task automatic send_tags(int n, logic en, logic idonly, string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge rx_clk);
      rx_tag_vld = ($urandom_range(0, 3) != 0);
      rx_tag = 16'($urandom);
      rx_hash_en = en; rx_id_only = idonly;
    end
    @(negedge rx_clk);
    rx_tag_vld = 0;
    repeat (4) @(negedge rx_clk);
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge rx_clk);
    cfg_rst_n = 1; rx_rst_n = 1;
    @(negedge rx_clk);
    check1("R8 reset vld", rx_res_vld, 1'b0);
    check1("R8 reset pass", rx_res_pass, 1'b0);
    // R1: zero table rejects everything when enabled
    send_tags(40, 1, 0, "R1");
    // R7: disabled passes everything
    cfg_write(16'hFFFF, 2'b11, 0); settle();
    cfg_write(16'h0000, 2'b11, 0); settle();
    send_tags(40, 0, 0, "R7");
    // R5: only bit 8 set, index 4'b1000 must pass
    cfg_write(16'h0100, 2'b11, 0); settle();
    send_tags(80, 1, 0, "R5");
    send_tags(80, 1, 1, "R5");
    // R4/R6: mixed table, both tag modes
    cfg_write(16'hA5C3, 2'b11, 0); settle();
    send_tags(100, 1, 0, "R4");
    send_tags(100, 1, 1, "R6");
    // R3 little-endian: low lane alone does not copy
    cfg_write(16'h005A, 2'b01, 0); settle();
    send_tags(60, 1, 0, "R3");
    cfg_write(16'h3C00, 2'b10, 0); settle();
    send_tags(60, 1, 1, "R3");
    // R3 big-endian: high lane alone does not copy
    cfg_write(16'hF000, 2'b10, 1); settle();
    send_tags(60, 1, 0, "R3");
    cfg_write(16'h0011, 2'b01, 1); settle();
    send_tags(60, 1, 1, "R3");
    // R9: back-to-back trigger writes, last one wins
    for (int k = 0; k < 4; k++) begin
      @(negedge cfg_clk);
      cfg_wr_en = 1; cfg_wr_be = 2'b11; cfg_big_endian = 0;
      cfg_wr_data = 16'($urandom);
      m_cfg_tbl = cfg_wr_data; m_rx_tbl = cfg_wr_data;
    end
    @(negedge cfg_clk);
    cfg_wr_en = 0; cfg_wr_be = '0;
    settle();
    send_tags(100, 1, 0, "R9");
    send_tags(100, 1, 1, "R9");
    // R2: random lane patterns, trigger afterwards
    for (int k = 0; k < 6; k++) begin
      logic big = 1'($urandom);
      cfg_write(16'($urandom), big ? 2'b10 : 2'b01, big);
      cfg_write(16'($urandom), big ? 2'b01 : 2'b10, big);
      settle();
      send_tags(50, 1, 1'(k), "R2");
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule